// File: doc/BRIEF.md
# Five-wire SPI master with slave-ready hold-off

This block is an SPI master for one slave. It drives a chip select, a serial clock and a data-out line, and it samples a data-in line. A fifth wire, driven by the slave, is an active-low ready line. The master will not start the serial clock for a word until that line says the slave can take part. All four combinations of clock polarity and clock phase are supported. The serial bit period is an even number of system clocks, set by a divider input.

A word is handed over on a parallel load port with a one-cycle strobe. A busy flag shows when a new load is refused. The gap from select assertion to the first clock edge can be stretched by a 5-bit delay input. The gap from the last clock edge to select release can be stretched by a second 5-bit delay input. Both extensions are counted in system clocks. In hold mode the select line stays asserted after a word, so that the next word follows without a release. Clearing the hold input while the master is parked releases the select.

Top module: `spi5_master`

## Requirements
- R1: When select is high and polarity is steady, the serial clock rests at the polarity level (0 or 1). A word makes exactly 16 clock transitions. Consecutive transitions are div/2 system clocks apart. The divider is even and at least 2.
- R2: Select assertion is followed by the first clock transition after a fixed number of system clocks, provided ready is already active. With phase 0 that number is 2 + c2t. With phase 1 it is div/2 + 2 + c2t.
- R3: Outside hold mode, select rises a fixed number of system clocks after the 16th transition. With phase 1 that number is 1 + t2c. With phase 0 it is div/2 + 1 + t2c.
- R4: The output data line carries the loaded word most significant bit first. With phase 0, each bit is valid before the odd-numbered (leading) transitions and changes on the even-numbered ones. With phase 1, each bit changes on the odd-numbered transitions.
- R5: The input data line is sampled on the leading transitions with phase 0 and on the trailing ones with phase 1, shifting most significant bit first. rx_data holds the received word when done pulses. done is high for exactly one cycle per word, and busy is low in that cycle.
- R6: The ready input is active low and passes through a two-flop synchronizer. While ready is inactive no clock transition starts a word. Once the setup gap has elapsed, the first transition comes 3 system clocks after ready goes low.
- R7: With hold set when the word is loaded, select stays low after the word while done pulses and busy drops. The next load starts without releasing select. Clearing hold while parked raises select one cycle later.
- R8: A word loaded while select is held still waits for ready: no clock transition occurs while ready is inactive.
- R9: busy rises in the cycle after an accepted load. A load while busy is ignored, and no second word follows from it.
- R10: After reset, select is high, busy and done are low and the clock rests at the polarity level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cpol | input | 1 | Clock polarity (resting level) |
| cfg_cpha | input | 1 | Clock phase: 0 samples on leading transitions, 1 on trailing |
| cfg_hold | input | 1 | Keep select asserted between words |
| cfg_div | input | 8 | Bit period in system clocks, even, at least 2 |
| cfg_c2t | input | 5 | Extra system clocks from select assertion to first clock transition |
| cfg_t2c | input | 5 | Extra system clocks from last clock transition to select release |
| ld_valid | input | 1 | One-cycle load strobe |
| ld_data | input | 8 | Word to transmit |
| busy | output | 1 | High while a word is in progress; loads are refused |
| done | output | 1 | One-cycle pulse when a word completes |
| rx_data | output | 8 | Last received word |
| ss_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to slave |
| miso | input | 1 | Serial data from slave |
| rdy_n | input | 1 | Active-low slave ready |

## Verification
The sweep covers every polarity and phase with several dividers and both delay extensions. For each word it measures the lead and trail gaps, the transition spacing and the bit order in both directions. A design that swapped the half-bit term between phases, or ignored a delay field, would be off by a known number of cycles. One with the wrong shift edge would corrupt the word. The ready tests hold the ready line inactive after select assertion, both from idle and while select is held. A master that skipped the hold-off, or left out the synchronizer latency, would clock early. A stray load during a word checks that a busy master neither corrupts the word nor queues a second one. Dropping hold while parked must raise select on the next cycle.

// File: rtl/spi5_pkg.sv
package spi5_pkg;

    localparam int WORD_W_DEF      = 8;
    localparam int DIV_W_DEF       = 8;
    localparam int DLY_W_DEF       = 5;
    localparam int SYNC_STAGES_DEF = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_SHIFT,
        ST_TAIL,
        ST_HELD
    } ctrl_st_t;

    typedef struct packed {
        logic cpol;
        logic cpha;
        logic hold;
    } mode_t;

    // System clocks from select assertion to the first clock transition.
    function automatic int lead_gap(int half, int c2t, logic cpha);
        return 2 + c2t + (cpha ? half : 0);
    endfunction

    // System clocks from the last clock transition to select release.
    function automatic int trail_gap(int half, int t2c, logic cpha);
        return 1 + t2c + (cpha ? 0 : half);
    endfunction

    // Transition n (1-based) is one where the output data moves.
    function automatic logic is_out_edge(int n, logic cpha);
        return ((n % 2) == 1) == cpha;
    endfunction

endpackage

// File: rtl/spi5_sync.sv
module spi5_sync #(
    parameter int  STAGES  = spi5_pkg::SYNC_STAGES_DEF,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain[i] <= RST_VAL;
                end else if (i == 0) begin
                    chain[i] <= din;
                end else begin
                    chain[i] <= chain[(i == 0) ? 0 : i-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/spi5_ctrl.sv
module spi5_ctrl
    import spi5_pkg::*;
#(
    parameter int WORD_W = WORD_W_DEF,
    parameter int DIV_W  = DIV_W_DEF,
    parameter int DLY_W  = DLY_W_DEF,
    localparam int EDGES = 2 * WORD_W,
    localparam int EW    = $clog2(EDGES) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_cpol,
    input  logic             cfg_cpha,
    input  logic             cfg_hold,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic [DLY_W-1:0] cfg_c2t,
    input  logic [DLY_W-1:0] cfg_t2c,
    input  logic             ld_valid,
    input  logic             rdy_ok,
    output logic             busy,
    output logic             done,
    output logic             ss_n,
    output logic             sclk,
    output logic             start,
    output logic             edge_stb,
    output logic [EW-1:0]    edge_num,
    output logic             cpha_q
);
    localparam int MAXW  = (DIV_W > DLY_W + 1) ? DIV_W : DLY_W + 1;
    localparam int CNT_W = MAXW + 1;

    ctrl_st_t           st;
    logic [CNT_W-1:0]   cnt;
    logic [EW-1:0]      ec;
    mode_t              mode_q;
    logic [DIV_W-2:0]   half_q;
    logic [DLY_W-1:0]   t2c_q;
    logic [DIV_W-2:0]   half_in;
    logic               accept;
    logic               cnt_zero;
    logic [CNT_W-1:0]   lead_cnt;
    logic [CNT_W-1:0]   trail_cnt;
    logic [CNT_W-1:0]   half_cnt;

    // A divider below 2 behaves as 2.
    assign half_in  = (cfg_div[DIV_W-1:1] == '0) ? (DIV_W-1)'(1) : cfg_div[DIV_W-1:1];
    assign accept   = ld_valid && ((st == ST_IDLE) || (st == ST_HELD));
    assign cnt_zero = (cnt == '0);

    assign lead_cnt  = CNT_W'(lead_gap(int'(half_in), int'(cfg_c2t), cfg_cpha) - 1);
    assign trail_cnt = CNT_W'(trail_gap(int'(half_q), int'(t2c_q), mode_q.cpha) - 1);
    assign half_cnt  = CNT_W'(half_q) - CNT_W'(1);

    assign edge_stb = cnt_zero && (((st == ST_SETUP) && rdy_ok) || (st == ST_SHIFT));
    assign edge_num = (st == ST_SETUP) ? EW'(1) : ec + EW'(1);
    assign busy     = (st == ST_SETUP) || (st == ST_SHIFT) || (st == ST_TAIL);
    assign start    = accept;
    assign cpha_q   = mode_q.cpha;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            ec     <= '0;
            mode_q <= '0;
            half_q <= (DIV_W-1)'(1);
            t2c_q  <= '0;
            ss_n   <= 1'b1;
            sclk   <= cfg_cpol;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    sclk <= cfg_cpol;
                    ss_n <= 1'b1;
                end
                ST_SETUP: begin
                    if (!cnt_zero) begin
                        cnt <= cnt - CNT_W'(1);
                    end else if (rdy_ok) begin
                        sclk <= ~sclk;
                        ec   <= EW'(1);
                        cnt  <= half_cnt;
                        st   <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (!cnt_zero) begin
                        cnt <= cnt - CNT_W'(1);
                    end else begin
                        sclk <= ~sclk;
                        ec   <= ec + EW'(1);
                        if (ec == EW'(EDGES - 1)) begin
                            st  <= ST_TAIL;
                            cnt <= trail_cnt;
                        end else begin
                            cnt <= half_cnt;
                        end
                    end
                end
                ST_TAIL: begin
                    if (!cnt_zero) begin
                        cnt <= cnt - CNT_W'(1);
                    end else begin
                        done <= 1'b1;
                        if (mode_q.hold) begin
                            st <= ST_HELD;
                        end else begin
                            ss_n <= 1'b1;
                            st   <= ST_IDLE;
                        end
                    end
                end
                ST_HELD: begin
                    sclk <= mode_q.cpol;
                    if (!cfg_hold) begin
                        ss_n <= 1'b1;
                        st   <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase

            if (accept) begin
                mode_q <= '{cpol: cfg_cpol, cpha: cfg_cpha, hold: cfg_hold};
                half_q <= half_in;
                t2c_q  <= cfg_t2c;
                cnt    <= lead_cnt;
                ss_n   <= 1'b0;
                st     <= ST_SETUP;
            end
        end
    end
endmodule

// File: rtl/spi5_shift.sv
module spi5_shift
    import spi5_pkg::*;
#(
    parameter int WORD_W = WORD_W_DEF,
    localparam int EDGES = 2 * WORD_W,
    localparam int EW    = $clog2(EDGES) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              edge_stb,
    input  logic [EW-1:0]     edge_num,
    input  logic              cpha,
    input  logic              miso,
    output logic              mosi,
    output logic [WORD_W-1:0] rx_word
);
    logic [WORD_W-1:0] tx;
    logic              out_edge;
    logic              moves;

    assign out_edge = is_out_edge(int'(edge_num), cpha);
    // The first bit is presented before transition 1 (phase 0) or on it
    // (phase 1), and the last transition never advances the word.
    assign moves    = out_edge && (edge_num > EW'(1)) && (edge_num < EW'(EDGES));

    always_ff @(posedge clk) begin
        if (rst) begin
            tx      <= '0;
            rx_word <= '0;
        end else if (start) begin
            tx <= tx_word;
        end else if (edge_stb) begin
            if (moves) begin
                tx <= {tx[WORD_W-2:0], 1'b0};
            end
            if (!out_edge) begin
                rx_word <= {rx_word[WORD_W-2:0], miso};
            end
        end
    end

    assign mosi = tx[WORD_W-1];
endmodule

// File: rtl/spi5_master.sv
module spi5_master
    import spi5_pkg::*;
#(
    parameter int WORD_W      = WORD_W_DEF,
    parameter int DIV_W       = DIV_W_DEF,
    parameter int DLY_W       = DLY_W_DEF,
    parameter int SYNC_STAGES = SYNC_STAGES_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic              cfg_hold,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [DLY_W-1:0]  cfg_c2t,
    input  logic [DLY_W-1:0]  cfg_t2c,
    input  logic              ld_valid,
    input  logic [WORD_W-1:0] ld_data,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] rx_data,
    output logic              ss_n,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    input  logic              rdy_n
);
    localparam int EW = $clog2(2 * WORD_W) + 1;

    logic          rdy_n_s;
    logic          rdy_ok;
    logic          start;
    logic          edge_stb;
    logic [EW-1:0] edge_num;
    logic          cpha_q;

    spi5_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rdy_n),
        .dout (rdy_n_s)
    );

    assign rdy_ok = ~rdy_n_s;

    spi5_ctrl #(.WORD_W(WORD_W), .DIV_W(DIV_W), .DLY_W(DLY_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .cfg_cpol (cfg_cpol),
        .cfg_cpha (cfg_cpha),
        .cfg_hold (cfg_hold),
        .cfg_div  (cfg_div),
        .cfg_c2t  (cfg_c2t),
        .cfg_t2c  (cfg_t2c),
        .ld_valid (ld_valid),
        .rdy_ok   (rdy_ok),
        .busy     (busy),
        .done     (done),
        .ss_n     (ss_n),
        .sclk     (sclk),
        .start    (start),
        .edge_stb (edge_stb),
        .edge_num (edge_num),
        .cpha_q   (cpha_q)
    );

    spi5_shift #(.WORD_W(WORD_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .tx_word  (ld_data),
        .edge_stb (edge_stb),
        .edge_num (edge_num),
        .cpha     (cpha_q),
        .miso     (miso),
        .mosi     (mosi),
        .rx_word  (rx_data)
    );
endmodule

// File: rtl/spi5_master_chk.sv
module spi5_master_chk (
    input logic clk,
    input logic rst,
    input logic cfg_cpol,
    input logic ld_valid,
    input logic busy,
    input logic done,
    input logic ss_n,
    input logic sclk
);
    // R1: clock rests at the polarity level while deselected
    a_r1_sclk_idle: assert property (@(posedge clk) disable iff (rst)
        (ss_n && $past(ss_n) && $stable(cfg_cpol)) |-> (sclk == cfg_cpol));

    // R4: clock transitions during a word only happen while selected
    a_r4_sclk_selected: assert property (@(posedge clk) disable iff (rst)
        (!$stable(sclk) && $past(busy)) |-> !ss_n);

    // R5: done is a single-cycle pulse
    a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R5: busy is low while done pulses
    a_r5_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R3: a release at the end of a word coincides with done
    a_r3_release_done: assert property (@(posedge clk) disable iff (rst)
        ($rose(ss_n) && $past(busy)) |-> done);

    // R9: an accepted load makes the master busy next cycle
    a_r9_busy_after_load: assert property (@(posedge clk) disable iff (rst)
        (!busy && ld_valid) |=> busy);
endmodule

bind spi5_master spi5_master_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_cpol (cfg_cpol),
    .ld_valid (ld_valid),
    .busy     (busy),
    .done     (done),
    .ss_n     (ss_n),
    .sclk     (sclk)
);

// File: tb/spi5_master_test.sv
module spi5_master_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_hold = 1'b0;
    logic [7:0] cfg_div = 8'd2;
    logic [4:0] cfg_c2t = 5'd0, cfg_t2c = 5'd0;
    logic       ld_valid = 1'b0;
    logic [7:0] ld_data = 8'h00;
    logic       busy, done, ss_n, sclk, mosi;
    logic [7:0] rx_data;
    logic       miso = 1'b0;
    logic       rdy_n = 1'b0;

    int errs = 0, checks = 0, cyc = 0;
    int t_ld, t_first, t_last, t_rise, nedges, bad_per, done_cnt, oidx, mhalf;
    logic [7:0] srx, stx, rxcap;
    logic pss = 1'b1, psclk = 1'b0, pbusy = 1'b0, mcpha = 1'b0;
    bit   finished = 0;

    spi5_master uut (
        .clk(clk), .rst(rst), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .cfg_hold(cfg_hold), .cfg_div(cfg_div), .cfg_c2t(cfg_c2t), .cfg_t2c(cfg_t2c),
        .ld_valid(ld_valid), .ld_data(ld_data), .busy(busy), .done(done),
        .rx_data(rx_data), .ss_n(ss_n), .sclk(sclk), .mosi(mosi), .miso(miso),
        .rdy_n(rdy_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Slave model and measurement, all at the falling edge.
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (ld_valid && !pbusy) begin
                t_ld = cyc; t_first = -1; t_rise = -1; nedges = 0; bad_per = 0;
                done_cnt = 0; srx = 8'h00; mcpha = cfg_cpha; mhalf = cfg_div / 2;
                if (!cfg_cpha) begin miso = stx[7]; oidx = 1; end
                else oidx = 0;
            end
            if (!pss && ss_n) t_rise = cyc;
            if (sclk != psclk && !ss_n) begin
                nedges++;
                if (nedges == 1) t_first = cyc;
                else if (cyc - t_last != mhalf) bad_per++;
                t_last = cyc;
                if (((nedges % 2) == 1) == !mcpha) srx = {srx[6:0], mosi};
                else if (oidx < 8) begin miso = stx[7 - oidx]; oidx++; end
            end
            if (done) begin done_cnt++; rxcap = rx_data; end
        end
        pss = ss_n; psclk = sclk; pbusy = busy;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic start_word(input logic cpol, input logic cpha, input int div,
                              input int c2t, input int t2c, input logic hold,
                              input logic [7:0] txw, input logic [7:0] slw);
        @(negedge clk); #1;
        cfg_cpol = cpol; cfg_cpha = cpha; cfg_div = 8'(div);
        cfg_c2t = 5'(c2t); cfg_t2c = 5'(t2c); cfg_hold = hold; stx = slw;
        @(negedge clk); #1;
        ld_data = txw; ld_valid = 1'b1;
        @(negedge clk); #1;
        ld_valid = 1'b0;
    endtask

    task automatic finish_word(input logic cpol, input logic cpha, input int div,
                               input int c2t, input int t2c, input logic hold,
                               input logic [7:0] txw, input logic [7:0] slw,
                               input bit check_lead);
        int h;
        h = div / 2;
        for (int i = 0; i < 2000 && done_cnt == 0; i++) @(negedge clk);
        #1;
        chk(busy == 1'b0, "R5", "busy low at done", int'(busy), 0);
        repeat (3) @(negedge clk);
        #1;
        if (check_lead)
            chk(t_first - t_ld == 2 + c2t + (cpha ? h : 0), "R2", "lead gap",
                t_first - t_ld, 2 + c2t + (cpha ? h : 0));
        if (!hold)
            chk(t_rise - t_last == 1 + t2c + (cpha ? 0 : h), "R3", "trail gap",
                t_rise - t_last, 1 + t2c + (cpha ? 0 : h));
        else
            chk(ss_n == 1'b0 && t_rise == -1, "R7", "select held", int'(ss_n), 0);
        chk(nedges == 16, "R1", "transition count", nedges, 16);
        chk(bad_per == 0, "R1", "transition spacing", bad_per, 0);
        chk(sclk == cpol, "R1", "rest level", int'(sclk), int'(cpol));
        chk(srx == txw, "R4", "mosi word", int'(srx), int'(txw));
        chk(rxcap == slw, "R5", "rx_data", int'(rxcap), int'(slw));
        chk(done_cnt == 1, "R5", "done pulses", done_cnt, 1);
    endtask

    initial begin
        repeat (120000) @(posedge clk);
        if (!finished) begin
            errs++; checks++;
            $display("FAIL watchdog: actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        int idx, tref;
        repeat (4) @(negedge clk);
        #1 rst = 1'b0;
        @(negedge clk); #1;
        // R10 reset state
        chk(ss_n == 1'b1, "R10", "ss_n", int'(ss_n), 1);
        chk(busy == 1'b0, "R10", "busy", int'(busy), 0);
        chk(done == 1'b0, "R10", "done", int'(done), 0);
        chk(sclk == 1'b0, "R10", "sclk", int'(sclk), 0);
        repeat (3) @(negedge clk);

        // Sweep of modes, dividers and delay extensions (R1..R5).
        idx = 0;
        for (int m = 0; m < 4; m++)
            for (int d = 1; d <= 3; d++)
                for (int a = 0; a < 2; a++)
                    for (int b = 0; b < 2; b++) begin
                        logic [7:0] tw, sw;
                        tw = 8'(idx * 37 + 11);
                        sw = ~8'(idx * 53 + 5);
                        start_word(m[1], m[0], 2 * d, a * 5, b * 3, 1'b0, tw, sw);
                        finish_word(m[1], m[0], 2 * d, a * 5, b * 3, 1'b0, tw, sw, 1'b1);
                        idx++;
                    end

        // R6: ready held inactive after select assertion.
        @(negedge clk); #1 rdy_n = 1'b1;
        repeat (3) @(negedge clk);
        start_word(1'b0, 1'b0, 4, 0, 0, 1'b0, 8'hC3, 8'h5A);
        repeat (20) @(negedge clk);
        #1;
        chk(nedges == 0, "R6", "no clock while unready", nedges, 0);
        chk(ss_n == 1'b0, "R6", "select asserted while waiting", int'(ss_n), 0);
        tref = cyc;
        rdy_n = 1'b0;
        finish_word(1'b0, 1'b0, 4, 0, 0, 1'b0, 8'hC3, 8'h5A, 1'b0);
        chk(t_first == tref + 3, "R6", "first edge after ready", t_first - tref, 3);

        // R7/R8: hold mode, second word waits for ready.
        start_word(1'b1, 1'b1, 2, 1, 2, 1'b1, 8'h96, 8'h0F);
        finish_word(1'b1, 1'b1, 2, 1, 2, 1'b1, 8'h96, 8'h0F, 1'b1);
        #1 rdy_n = 1'b1;
        repeat (3) @(negedge clk);
        start_word(1'b1, 1'b1, 2, 1, 2, 1'b1, 8'h3E, 8'hE1);
        repeat (15) @(negedge clk);
        #1;
        chk(nedges == 0, "R8", "held word waits for ready", nedges, 0);
        chk(ss_n == 1'b0, "R8", "select still held", int'(ss_n), 0);
        rdy_n = 1'b0;
        finish_word(1'b1, 1'b1, 2, 1, 2, 1'b1, 8'h3E, 8'hE1, 1'b0);
        @(negedge clk); #1;
        cfg_hold = 1'b0;
        tref = cyc;
        @(negedge clk); #1;
        chk(ss_n == 1'b1 && t_rise == tref + 1, "R7", "release on hold clear",
            t_rise - tref, 1);

        // R9: load while busy is ignored.
        repeat (3) @(negedge clk);
        start_word(1'b0, 1'b1, 4, 2, 1, 1'b0, 8'hA5, 8'h69);
        chk(busy == 1'b1, "R9", "busy after load", int'(busy), 1);
        repeat (4) @(negedge clk);
        #1 ld_data = 8'h3C; ld_valid = 1'b1;
        @(negedge clk); #1 ld_valid = 1'b0;
        finish_word(1'b0, 1'b1, 4, 2, 1, 1'b0, 8'hA5, 8'h69, 1'b1);
        repeat (20) @(negedge clk);
        #1;
        chk(ss_n == 1'b1 && nedges == 16, "R9", "no second word", nedges, 16);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule